// File: doc/BRIEF.md
# Status-Tagged Receive Queue

This block sits between a serial deserialiser and a bus slave. Each character that arrives comes with two tags, one for a framing error and one for a line break. The block stores the character and its tags in a first-in, first-out queue of 64 entries. Software drains the queue through a 32-bit read word. Each read word carries the byte, its two tags and a flag that says the queue had nothing to give. The same read port therefore serves as both the data path and the status path.

The block raises two requests. The trigger request stays high while the fill count is at or above a threshold chosen from a small code table. The timeout request fires when bytes remain in the queue and no byte has arrived and no read has happened for a chosen number of character times. A character-time pulse from the baud logic measures that interval. This lets software collect a partial batch that never reaches the threshold.

A combined level word reports the receive count in its low byte. The high byte passes through the transmit count of a neighbouring queue. A sticky overrun flag records any byte that was lost because the queue was full.

Top module: `rxq_status_fifo`

## Requirements
- R1: A read of a non-empty queue makes `rd_word` hold the oldest byte in bits 7:0. Bit 9 holds that byte's framing tag, bit 10 its break tag, and bit 8 is 0. Bits 31:11 are 0. The new value appears on the clock edge that samples `rd_en`.
- R2: A read of an empty queue makes `rd_word` equal 0x100: bit 8 set, data and tags 0. The fill count and the order of later bytes do not change.
- R3: Bytes leave in the order they arrived. All 64 entries can be filled and read back intact.
- R4: `level_word` bits 7:0 hold the receive fill count, and bits 15:8 hold `tx_level`. Both are registered, so the value reflects the state after the most recent clock edge.
- R5: `trig_req` is high exactly while the fill count is at or above the threshold. The threshold comes from `trig_sel` as follows: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 16, 4 gives 32, and 5, 6 or 7 give 48.
- R6: A byte that arrives while 64 entries are held is dropped, and the count stays 64. `ovr_flag` is set and stays set until `ovr_clr` is pulsed. If both happen in the same cycle, the set wins.
- R7: `tmo_sel` picks the timeout: 0 turns it off, 1 means 4 character ticks, 2 means 8 and 3 means 16. `tmo_req` rises on the edge that counts the last tick.
- R8: Every incoming byte and every read restarts the tick count and drops `tmo_req`. `tmo_req` is never high while the queue is empty.
- R9: After reset the count is 0, `rd_word` is 0x100, and `trig_req`, `tmo_req` and `ovr_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One-cycle strobe: a received byte is present |
| in_data | input | 8 | Received byte |
| in_ferr | input | 1 | Framing-error tag of the byte |
| in_brk | input | 1 | Break tag of the byte |
| char_tick | input | 1 | One pulse per character time |
| rd_en | input | 1 | Read strobe, pops one entry when non-empty |
| trig_sel | input | 3 | Trigger threshold code |
| tmo_sel | input | 2 | Idle timeout code |
| tx_level | input | 8 | Transmit fill count, passed into the level word |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_word | output | 32 | Tagged read word |
| level_word | output | 16 | Transmit count and receive count |
| trig_req | output | 1 | Fill count at or above threshold |
| tmo_req | output | 1 | Idle timeout with data pending |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The bench reads an empty queue between valid reads. A design that popped anyway would lose track of the entries, and a later read would return the wrong byte or a nonzero data field with the empty flag. It fills all 64 entries and then pushes one more. A design with an off-by-one full test would either store the extra byte or refuse the last good one, and the level and readback order would expose this. The bench steps the trigger across the 47/48 boundary with the reserved codes and counts ticks to one short of each timeout limit. It also inserts a restarting byte partway through a timeout count. A design that counted ticks while empty, or kept counting across the restart, would raise `tmo_req` early.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic [7:0] data;
  } rxq_entry_t;

  function automatic int unsigned trig_threshold(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 32;
      default: return 48;
    endcase
  endfunction

  function automatic int unsigned idle_limit(input logic [1:0] code);
    case (code)
      2'd1:    return 4;
      2'd2:    return 8;
      2'd3:    return 16;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  rxq_entry_t       push_entry,
  input  logic             pop,
  output rxq_entry_t       head_q,
  output logic             pop_ok,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             full
);

  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  rxq_entry_t        mem [DEPTH];
  logic              push_ok;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (cnt_q != '0);

  always_comb begin
    cnt_nxt = cnt_q;
    if (push_ok && !pop_ok) cnt_nxt = cnt_q + 1'b1;
    else if (!push_ok && pop_ok) cnt_nxt = cnt_q - 1'b1;
  end

  // storage array: write port and registered read port, no reset
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) head_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      cnt_q <= cnt_nxt;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH)); // R3

  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pop && cnt_q == '0 && !push) |=> (cnt_q == '0 && $stable(rd_ptr))); // R2

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (cnt_q == CNT_W'(DEPTH) && $stable(wr_ptr))); // R6

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
  import rxq_pkg::*;
#(
  parameter int TICK_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       tick,
  input  logic       has_data,
  input  logic [1:0] sel,
  output logic       tmo_req
);

  logic [TICK_W-1:0] idle_q;
  logic [TICK_W-1:0] limit;

  assign limit = TICK_W'(idle_limit(sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q  <= '0;
      tmo_req <= 1'b0;
    end else if (restart || !has_data || sel == 2'd0) begin
      idle_q  <= '0;
      tmo_req <= 1'b0;
    end else if (tick && !tmo_req) begin
      idle_q <= idle_q + 1'b1;
      if (idle_q + 1'b1 >= limit) tmo_req <= 1'b1;
    end
  end

  AST_TMO_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    tmo_req |-> has_data); // R8

  AST_TMO_OFF: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'd0) |=> !tmo_req); // R7

  AST_TMO_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tmo_req); // R8

endmodule

// File: rtl/rxq_status_fifo.sv
module rxq_status_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LVL_W  = 8,
  parameter int WORD_W = 32,
  parameter int TICK_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_ferr,
  input  logic              in_brk,
  input  logic              char_tick,
  input  logic              rd_en,
  input  logic [2:0]        trig_sel,
  input  logic [1:0]        tmo_sel,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic              ovr_clr,
  output logic [WORD_W-1:0] rd_word,
  output logic [2*LVL_W-1:0] level_word,
  output logic              trig_req,
  output logic              tmo_req,
  output logic              ovr_flag
);

  rxq_entry_t       in_entry, head_q;
  logic             pop_ok, full;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             empty_rd_q;

  assign in_entry = '{brk: in_brk, ferr: in_ferr, data: in_data};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .push(in_valid), .push_entry(in_entry),
    .pop(rd_en), .head_q(head_q), .pop_ok(pop_ok),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .full(full)
  );

  rxq_idle_timer #(.TICK_W(TICK_W)) u_timer (
    .clk(clk), .rst(rst),
    .restart(in_valid || rd_en), .tick(char_tick),
    .has_data(cnt_q != '0), .sel(tmo_sel),
    .tmo_req(tmo_req)
  );

  // read-word flag: set when the last read found nothing
  always_ff @(posedge clk) begin
    if (rst) empty_rd_q <= 1'b1;
    else if (rd_en) empty_rd_q <= !pop_ok;
  end

  assign rd_word = {{(WORD_W-11){1'b0}},
                    head_q.brk & ~empty_rd_q,
                    head_q.ferr & ~empty_rd_q,
                    empty_rd_q,
                    head_q.data & {8{~empty_rd_q}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      level_word <= '0;
      trig_req   <= 1'b0;
      ovr_flag   <= 1'b0;
    end else begin
      level_word <= {tx_level, LVL_W'(cnt_nxt)};
      trig_req   <= (cnt_nxt >= CNT_W'(trig_threshold(trig_sel)));
      if (in_valid && full) ovr_flag <= 1'b1;
      else if (ovr_clr)     ovr_flag <= 1'b0;
    end
  end

  AST_RD_EMPTY_FLAG: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cnt_q == '0) |=> (rd_word[8] && rd_word[7:0] == 8'h00)); // R2

  AST_RD_VALID_FLAG: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cnt_q != '0) |=> !rd_word[8]); // R1

  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && full) |=> ovr_flag); // R6

  AST_TRIG_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (trig_req == (cnt_q >= CNT_W'(trig_threshold($past(trig_sel)))))); // R5

  AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (level_word[LVL_W-1:0] == LVL_W'(cnt_q))); // R4

endmodule

// File: tb/rxq_status_fifo_test.sv
module rxq_status_fifo_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ferr, in_brk, char_tick, rd_en, ovr_clr;
  logic [7:0]  in_data, tx_level;
  logic [2:0]  trig_sel;
  logic [1:0]  tmo_sel;
  logic [31:0] rd_word;
  logic [15:0] level_word;
  logic        trig_req, tmo_req, ovr_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rxq_status_fifo uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ferr(in_ferr), .in_brk(in_brk), .char_tick(char_tick),
    .rd_en(rd_en), .trig_sel(trig_sel), .tmo_sel(tmo_sel),
    .tx_level(tx_level), .ovr_clr(ovr_clr), .rd_word(rd_word),
    .level_word(level_word), .trig_req(trig_req), .tmo_req(tmo_req),
    .ovr_flag(ovr_flag)
  );

  // vector: op[31:30] fe[29] brk[28] data[27:20] word[19:9] level[8:2]
  function automatic logic [31:0] mkv(input logic [1:0] op, input logic fe,
      input logic brk, input logic [7:0] d, input logic [10:0] w,
      input logic [6:0] l);
    return {op, fe, brk, d, w, l, 2'b00};
  endfunction

  localparam int NV = 12;
  localparam logic [1:0] OP_PUSH = 2'd1, OP_READ = 2'd2;
  localparam logic [31:0] VEC [NV] = '{
    mkv(OP_PUSH, 1'b0, 1'b0, 8'hA5, 11'h000, 7'd1),
    mkv(OP_PUSH, 1'b1, 1'b0, 8'h3C, 11'h000, 7'd2),
    mkv(OP_PUSH, 1'b0, 1'b1, 8'h00, 11'h000, 7'd3),
    mkv(OP_PUSH, 1'b0, 1'b0, 8'h7E, 11'h000, 7'd4),
    mkv(OP_READ, 1'b0, 1'b0, 8'h00, 11'h0A5, 7'd3),
    mkv(OP_READ, 1'b0, 1'b0, 8'h00, 11'h23C, 7'd2),
    mkv(OP_READ, 1'b0, 1'b0, 8'h00, 11'h400, 7'd1),
    mkv(OP_PUSH, 1'b1, 1'b1, 8'h81, 11'h000, 7'd2),
    mkv(OP_READ, 1'b0, 1'b0, 8'h00, 11'h07E, 7'd1),
    mkv(OP_READ, 1'b0, 1'b0, 8'h00, 11'h681, 7'd0),
    mkv(OP_READ, 1'b0, 1'b0, 8'h00, 11'h100, 7'd0),
    mkv(OP_READ, 1'b0, 1'b0, 8'h00, 11'h100, 7'd0)
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic fe,
                      input logic brk, input logic rd, input logic tk);
    @(negedge clk);
    in_valid = v; in_data = d; in_ferr = fe; in_brk = brk;
    rd_en = rd; char_tick = tk;
    @(negedge clk);
    in_valid = 1'b0; in_ferr = 1'b0; in_brk = 1'b0;
    rd_en = 1'b0; char_tick = 1'b0;
  endtask

  task automatic push_b(input logic [7:0] d); step(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0); endtask
  task automatic do_read();                   step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0); endtask
  task automatic idle();                      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0); endtask
  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = 8'h00; in_ferr = 1'b0; in_brk = 1'b0;
    char_tick = 1'b0; rd_en = 1'b0; ovr_clr = 1'b0; tx_level = 8'h00;
    trig_sel = 3'd5; tmo_sel = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9: reset state
    chk("R9 level", 32'(level_word), 32'h0);
    chk("R9 rd_word", rd_word, 32'h100);
    chk("R9 trig", 32'(trig_req), 32'h0);
    chk("R9 tmo", 32'(tmo_req), 32'h0);
    chk("R9 ovr", 32'(ovr_flag), 32'h0);

    // R1 R2 R4: vector table
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      step(v[31:30] == OP_PUSH, v[27:20], v[29], v[28], v[31:30] == OP_READ, 1'b0);
      chk("R4 level vector", 32'(level_word), {25'h0, v[8:2]});
      if (v[31:30] == OP_READ) chk("R1 R2 word vector", rd_word, {21'h0, v[19:9]});
    end

    // R4: transmit count passthrough
    tx_level = 8'h2A;
    idle();
    chk("R4 tx field", 32'(level_word), 32'h2A00);
    tx_level = 8'h00;

    // R5: threshold code 1 is 4
    trig_sel = 3'd1;
    idle();
    push_b(8'h01); push_b(8'h02); push_b(8'h03);
    chk("R5 below 4", 32'(trig_req), 32'h0);
    push_b(8'h04);
    chk("R5 at 4", 32'(trig_req), 32'h1);
    do_read();
    chk("R5 drop at 3", 32'(trig_req), 32'h0);
    trig_sel = 3'd0;
    idle();
    chk("R5 code0 one byte", 32'(trig_req), 32'h1);
    for (int k = 0; k < 70; k++) do_read();
    chk("R2 drained", 32'(level_word), 32'h0);
    chk("R5 empty no trig", 32'(trig_req), 32'h0);

    // R3 R5 R6: fill to depth with reserved code 7 (48)
    trig_sel = 3'd7;
    idle();
    for (int i = 0; i < 64; i++) begin
      push_b(8'(i));
      if (i == 46) chk("R5 47 entries", 32'(trig_req), 32'h0);
      if (i == 47) chk("R5 48 entries", 32'(trig_req), 32'h1);
    end
    chk("R3 full level", 32'(level_word), 32'd64);
    chk("R6 no ovr yet", 32'(ovr_flag), 32'h0);
    push_b(8'hEE);
    chk("R6 ovr set", 32'(ovr_flag), 32'h1);
    chk("R6 level held", 32'(level_word), 32'd64);
    for (int i = 0; i < 64; i++) begin
      do_read();
      chk("R3 order", rd_word, 32'(i));
    end
    do_read();
    chk("R2 empty after drain", rd_word, 32'h100);
    chk("R6 ovr sticky", 32'(ovr_flag), 32'h1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    chk("R6 ovr cleared", 32'(ovr_flag), 32'h0);

    // R7 R8: timeout code 1 (4 ticks)
    tmo_sel = 2'd1;
    ticks(6);
    chk("R8 empty no tmo", 32'(tmo_req), 32'h0);
    push_b(8'h55);
    ticks(3);
    chk("R7 3 of 4 ticks", 32'(tmo_req), 32'h0);
    ticks(1);
    chk("R7 4 ticks", 32'(tmo_req), 32'h1);
    do_read();
    chk("R8 read clears", 32'(tmo_req), 32'h0);
    chk("R1 tmo byte", rd_word, 32'h55);

    // R8: restart by a new byte, code 2 (8 ticks)
    tmo_sel = 2'd2;
    push_b(8'h11);
    ticks(5);
    push_b(8'h22);
    ticks(7);
    chk("R8 restart 7 ticks", 32'(tmo_req), 32'h0);
    ticks(1);
    chk("R7 8 ticks", 32'(tmo_req), 32'h1);

    // R7: code 3 (16 ticks)
    tmo_sel = 2'd3;
    do_read();
    ticks(15);
    chk("R7 15 of 16", 32'(tmo_req), 32'h0);
    ticks(1);
    chk("R7 16 ticks", 32'(tmo_req), 32'h1);

    // R7: code 0 disables
    tmo_sel = 2'd0;
    do_read();
    push_b(8'h33);
    ticks(20);
    chk("R7 disabled", 32'(tmo_req), 32'h0);

    finish_run();
  end

endmodule